// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns four groups of external I/O pins into four interrupt request lines. Each group of pins is treated as one active-low source: the pins are synchronised to the core clock, combined so that any low pin makes the source low, and watched by an edge and level detector. The detector's trigger condition is set by a 2-bit sensitivity code. Two sources share each code.

The sensitivity codes sit in an 8-bit control register that software can read and write. A write can only change a code while the CPU's interrupt-disable flag is set. The remaining register bits are plain storage and are written freely. A detected edge latches a sticky pending bit, and the CPU's acknowledge for that source clears it. In the combined falling-edge-and-low-level mode, the request also stays high for as long as the source is held low.

Top module: `extint_ctrl`

## Requirements
- R1: After a synchronous reset with all pins high, `reg_rdata` reads 0x00, so every source is in mode 00, and `irq_req` is 0.
- R2: Source 0 is `pin_a[3:0]`, source 1 is `pin_f[2:0]`, source 2 is `pin_b[3:0]` and source 3 is `pin_b[7:4]`. A source is low when any of its pins is low, so a second pin falling while another pin of the same source is already low is not a new edge.
- R3: Code 00 (falling edge plus low level) latches a pending request on a falling edge. It also asserts the request while the source is low, even after an acknowledge.
- R4: Code 01 latches a request on a rising edge only. A falling edge raises no request.
- R5: Code 10 latches a request on a falling edge only. A rising edge raises none.
- R6: Code 11 latches a request on both rising and falling edges.
- R7: Register bits [4:3] hold the code for sources 0 and 1. Bits [7:6] hold the code for sources 2 and 3.
- R8: A write with `irq_dis` = 0 leaves bits [7:6] and [4:3] unchanged. With `irq_dis` = 1 they take the written value.
- R9: Register bits 5 and [2:0] take the written value regardless of `irq_dis`.
- R10: A latched request stays asserted until `ack` for that source is high at a clock edge. It drops after that edge unless a level request in code 00 or a new edge keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 4 | Pins of source 0, active low |
| pin_f | input | 3 | Pins of source 1, active low |
| pin_b | input | 8 | Low half feeds source 2, high half feeds source 3 |
| irq_dis | input | 1 | CPU interrupt-disable flag; unlocks the sensitivity codes |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| ack | input | 4 | Per-source acknowledge, clears the pending request |
| irq_req | output | 4 | Per-source interrupt request |

## Verification
Every source is driven through all four codes with the same sequence: a pin falls, the CPU acknowledges, then the pin rises. This tells apart modes that react to the fall, to the rise, or to the held level. A second pattern holds two pins of one source low in overlapping windows, which shows that only the first fall and the last rise of the combined signal count. Writes are tried with the interrupt-disable flag clear and then set, with data that touches both locked and free bits, and the read-back shows which bits moved.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENS_FALL_LOW = 2'b00,
        SENS_RISE     = 2'b01,
        SENS_FALL     = 2'b10,
        SENS_BOTH     = 2'b11
    } sens_e;

    // control register layout; field positions are decoded by the detectors
    typedef struct packed {
        sens_e      sens_hi;   // [7:6] sources 2 and 3
        logic       spare_hi;  // [5]
        sens_e      sens_lo;   // [4:3] sources 0 and 1
        logic [2:0] spare_lo;  // [2:0]
    } ctrl_t;

    localparam int NSRC   = 4;
    localparam int CTRL_W = $bits(ctrl_t);

    // which sensitivity field drives source idx
    function automatic sens_e sens_of(ctrl_t c, int idx);
        return (idx < 2) ? c.sens_lo : c.sens_hi;
    endfunction

    // select trigger condition for a mode
    function automatic logic hit_of(sens_e m, logic fall, logic rise);
        case (m)
            SENS_FALL_LOW: return fall;
            SENS_RISE:     return rise;
            SENS_FALL:     return fall;
            default:       return fall | rise;
        endcase
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '1;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '1;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/extint_edge.sv
module extint_edge
    import extint_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lvl,
    input  sens_e mode,
    input  logic  ack,
    output logic  req
);
    logic prev;
    logic pend;
    logic fall;
    logic rise;
    logic hit;

    assign fall = prev & ~lvl;
    assign rise = ~prev & lvl;
    assign hit  = hit_of(mode, fall, rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
            pend <= 1'b0;
        end else begin
            prev <= lvl;
            pend <= hit | (pend & ~ack);
        end
    end

    assign req = pend | ((mode == SENS_FALL_LOW) & ~lvl);
endmodule

// File: rtl/extint_reg.sv
module extint_reg
    import extint_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  logic  unlock,
    input  ctrl_t wdata,
    output ctrl_t ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we) begin
            ctrl.spare_hi <= wdata.spare_hi;
            ctrl.spare_lo <= wdata.spare_lo;
            if (unlock) begin
                ctrl.sens_hi <= wdata.sens_hi;
                ctrl.sens_lo <= wdata.sens_lo;
            end
        end
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int A_W   = 4,
    parameter int F_W   = 3,
    parameter int B_W   = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [A_W-1:0]   pin_a,
    input  logic [F_W-1:0]   pin_f,
    input  logic [B_W-1:0]   pin_b,
    input  logic             irq_dis,
    input  logic             reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]  ack,
    output logic [NSRC-1:0]  irq_req
);
    localparam int HB_W  = B_W / 2;
    localparam int ALL_W = A_W + F_W + B_W;

    ctrl_t            ctrl;
    logic [ALL_W-1:0] pins_s;
    logic [NSRC-1:0]  src_lvl;

    extint_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .unlock (irq_dis),
        .wdata  (ctrl_t'(reg_wdata)),
        .ctrl   (ctrl)
    );

    assign reg_rdata = ctrl;

    extint_sync #(.W(ALL_W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pin_b, pin_f, pin_a}),
        .q   (pins_s)
    );

    // any low pin pulls its source low
    assign src_lvl[0] = &pins_s[A_W-1:0];
    assign src_lvl[1] = &pins_s[A_W+F_W-1:A_W];
    assign src_lvl[2] = &pins_s[A_W+F_W+HB_W-1:A_W+F_W];
    assign src_lvl[3] = &pins_s[ALL_W-1:A_W+F_W+HB_W];

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            extint_edge u_edge (
                .clk  (clk),
                .rst  (rst),
                .lvl  (src_lvl[i]),
                .mode (sens_of(ctrl, i)),
                .ack  (ack[i]),
                .req  (irq_req[i])
            );
        end
    endgenerate
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
    import extint_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                irq_dis,
    input logic                reg_we,
    input logic [CTRL_W-1:0]   reg_wdata,
    input logic [CTRL_W-1:0]   reg_rdata,
    input logic [NSRC-1:0]     ack,
    input logic [NSRC-1:0]     irq_req
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (reg_rdata == '0 && irq_req == '0));

    p_locked_hi_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && irq_dis) |=> $stable(reg_rdata[7:6]));

    p_locked_lo_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && irq_dis) |=> $stable(reg_rdata[4:3]));

    p_free_bits_r9: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_rdata[5] == $past(reg_wdata[5]) &&
                    reg_rdata[2:0] == $past(reg_wdata[2:0])));

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_hold
            localparam int LO = (i < 2) ? 3 : 6;
            // R10: an edge-mode request only drops after an acknowledge
            p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
                ($fell(irq_req[i]) && $past(reg_rdata[LO+1:LO]) != 2'b00)
                |-> $past(ack[i]));
        end
    endgenerate
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_dis   (irq_dis),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ack       (ack),
    .irq_req   (irq_req)
);

// File: tb/sim_extint_ctrl.sv
module sim_extint_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [3:0] irq;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_a = '1;
    logic [2:0] pin_f = '1;
    logic [7:0] pin_b = '1;
    logic       irq_dis = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] ack = '0;
    logic [3:0] irq_req;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic [7:0] model = '0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl u0 (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_f(pin_f), .pin_b(pin_b),
        .irq_dis(irq_dis), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack(ack), .irq_req(irq_req)
    );

    // monitor: compare queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                n_tests++;
                if (irq_req !== e.irq || reg_rdata !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: irq=%b rd=%h expected irq=%b rd=%h",
                             e.tag, irq_req, reg_rdata, e.irq, e.rd);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input logic [3:0] irq, input string tag);
        exp_t e;
        e.irq = irq; e.rd = model; e.tag = tag;
        sb.push_back(e);
        do @(negedge clk); while (sb.size() != 0);
    endtask

    task automatic wr(input logic [7:0] d, input logic dis);
        irq_dis = dis; reg_we = 1'b1; reg_wdata = d;
        cyc(1);
        reg_we = 1'b0;
        if (dis) model = d;
        else     model = (model & 8'hD8) | (d & 8'h27);
    endtask

    task automatic ack_pulse(input logic [3:0] m);
        ack = m; cyc(1); ack = '0;
    endtask

    function automatic int src_w(input int s);
        return (s == 1) ? 3 : 4;
    endfunction

    task automatic set_pin(input int s, input int idx, input logic v);
        case (s)
            0: pin_a[idx] = v;
            1: pin_f[idx] = v;
            2: pin_b[idx] = v;
            default: pin_b[4+idx] = v;
        endcase
    endtask

    task automatic run_mode(input int s, input int m);
        int pos = (s < 2) ? 3 : 6;
        int idx = m % src_w(s);
        logic [3:0] bit_s = 4'(1 << s);
        string t;
        t = $sformatf("src%0d mode%0d", s, m);
        wr((model & ~(8'h3 << pos)) | 8'((m & 3) << pos), 1'b1);
        ack_pulse(4'hF); cyc(3);
        expect_now(4'h0, {t, " idle R7"});
        set_pin(s, idx, 1'b0); cyc(4);
        case (m)
            0: expect_now(bit_s, {t, " fall R3"});
            1: expect_now(4'h0,  {t, " fall ignored R4"});
            2: expect_now(bit_s, {t, " fall R5"});
            default: expect_now(bit_s, {t, " fall R6"});
        endcase
        if (m == 0) begin
            ack_pulse(bit_s); cyc(3);
            expect_now(bit_s, {t, " level after ack R3"});
        end
        set_pin(s, idx, 1'b1); cyc(4);
        case (m)
            0: expect_now(4'h0,  {t, " rise ignored R3"});
            1: expect_now(bit_s, {t, " rise R4"});
            2: expect_now(bit_s, {t, " pending held R5 R10"});
            default: expect_now(bit_s, {t, " rise R6"});
        endcase
        ack_pulse(bit_s); cyc(3);
        expect_now(4'h0, {t, " cleared by ack R10"});
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        expect_now(4'h0, "reset state R1");

        // write lock
        wr(8'hFF, 1'b0);
        expect_now(4'h0, "locked write, free bits R8 R9");
        wr(8'hD8, 1'b1);
        expect_now(4'h0, "unlocked write R8");
        wr(8'h00, 1'b0);
        expect_now(4'h0, "locked clear keeps codes R8 R9");
        wr(8'h00, 1'b1);
        expect_now(4'h0, "unlocked clear R8");

        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 4; m++)
                run_mode(s, m);

        // overlapping pins on source 1 in both-edge mode
        wr((model & 8'hE7) | 8'h18, 1'b1);
        ack_pulse(4'hF); cyc(3);
        pin_f[0] = 1'b0; cyc(4);
        expect_now(4'h2, "first pin low R2");
        ack_pulse(4'h2); cyc(2);
        pin_f[2] = 1'b0; cyc(4);
        expect_now(4'h0, "second pin no edge R2");
        pin_f[0] = 1'b1; cyc(4);
        expect_now(4'h0, "one pin still low R2");
        pin_f[2] = 1'b1; cyc(4);
        expect_now(4'h2, "last pin high rise R2 R6");
        ack_pulse(4'h2); cyc(3);
        expect_now(4'h0, "ack clears R10");

        // locked write attempt must not alter mode: source 0 stays both-edge
        wr(8'h00, 1'b0);
        pin_a[3] = 1'b0; cyc(4);
        expect_now(4'h1, "mode kept after locked write R8");
        pin_a[3] = 1'b1; ack_pulse(4'h1); cyc(5);
        expect_now(4'h1, "rise still seen R8 R6");
        ack_pulse(4'h1); cyc(3);
        expect_now(4'h0, "final clear R10");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule